// File: doc/BRIEF.md
# Supervisor Trap Value Capture

This block keeps the supervisor trap value register and the exception PC that goes with it. When the trap logic signals that an exception is being taken into supervisor mode, the block looks at the exception cause. From the cause it decides what the register captures:

- the faulting virtual address;
- the address of the faulting part of an access that spans two parts;
- the bits of the faulting instruction, zero-extended;
- or zero.

In the same cycle the exception PC captures the start address of the instruction.

Outside trap cycles only a software CSR write changes the trap value register. A trap wins over a software write in the same cycle. The parameter `ZERO_MASK` has one bit per cause code. A set bit makes that cause write zero, whatever the address or instruction inputs carry. The parameter `INSN_CAPTURE` chooses whether an illegal-instruction trap records the instruction bits or zero.

Reset is asserted asynchronously by an active-low input and released through a two-stage synchronizer. The registers leave reset on the second rising clock edge after the input goes high.

Top module: `sv_trapval`

## Requirements
- R1: While reset is active and after it is released, `tval_o` and `epc_o` read zero until the first trap or software write.
- R2: In a cycle with `trap_i`=0 and `sw_we_i`=0, `tval_o` keeps its value across the next clock edge.
- R3: In a cycle with `trap_i`=0 and `sw_we_i`=1, `tval_o` takes the full XLEN-bit `sw_wdata_i` at the next clock edge.
- R4: When `trap_i` and `sw_we_i` are both 1 in one cycle, the trap value is captured and `sw_wdata_i` is ignored.
- R5: On a trap with cause 0 (fetch misaligned), 3 (breakpoint), 4 (load misaligned) or 6 (store misaligned), `tval_o` captures `fault_va_i`, and `split_i` has no effect.
- R6: On a trap with cause 1 (fetch access), 5 (load access), 7 (store access), 12 (fetch page), 13 (load page) or 15 (store page), `tval_o` captures `part_va_i` when `split_i`=1 and `fault_va_i` when `split_i`=0.
- R7: On a trap with cause 2 (illegal instruction), `tval_o` captures `insn_i` zero-extended to XLEN when `INSN_CAPTURE`=1, and zero when `INSN_CAPTURE`=0.
- R8: On a trap with any cause not listed in R5 to R7, `tval_o` becomes zero.
- R9: On a trap whose cause c has `ZERO_MASK[c]`=1, `tval_o` becomes zero for every cause class.
- R10: `epc_o` captures `pc_i` on every trap and holds its value in all other cycles, software writes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| trap_i | input | 1 | Exception taken into supervisor mode this cycle |
| cause_i | input | CAUSE_W | Exception cause code |
| fault_va_i | input | XLEN | Faulting virtual address (base of the access or fetch) |
| split_i | input | 1 | Access spans two parts and a later part faulted |
| part_va_i | input | XLEN | Virtual address of the part that faulted |
| insn_i | input | ILEN | Bits of the faulting instruction |
| pc_i | input | XLEN | Start address of the trapping instruction |
| sw_we_i | input | 1 | Software CSR write enable |
| sw_wdata_i | input | XLEN | Software CSR write data |
| tval_o | output | XLEN | Trap value register |
| epc_o | output | XLEN | Exception PC register |

## Verification
Random cycles draw traps over every listed cause and several unlisted ones. The address, part address, instruction and PC inputs take independent random values, so a wrong source is seen at once. Whether the access is split is also random. This tells a base-address capture apart from a faulting-part capture, and shows whether misaligned causes ignore the split flag.

Directed cases cover several corners:
- a trap and a software write in the same cycle;
- masked causes that would otherwise carry an address;
- idle cycles after a write.

A second instance with instruction capture turned off runs on the same stimulus, to tell the two illegal-instruction options apart.

// File: rtl/sv_trapval_pkg.sv
package sv_trapval_pkg;

  localparam int unsigned CAUSE_FETCH_MISAL = 0;
  localparam int unsigned CAUSE_FETCH_ACC   = 1;
  localparam int unsigned CAUSE_ILLEGAL     = 2;
  localparam int unsigned CAUSE_BREAK       = 3;
  localparam int unsigned CAUSE_LOAD_MISAL  = 4;
  localparam int unsigned CAUSE_LOAD_ACC    = 5;
  localparam int unsigned CAUSE_STORE_MISAL = 6;
  localparam int unsigned CAUSE_STORE_ACC   = 7;
  localparam int unsigned CAUSE_FETCH_PAGE  = 12;
  localparam int unsigned CAUSE_LOAD_PAGE   = 13;
  localparam int unsigned CAUSE_STORE_PAGE  = 15;

  // Class of value captured on a trap
  typedef enum logic [1:0] {
    TV_ZERO = 2'd0,  // write zero
    TV_ADDR = 2'd1,  // base faulting address
    TV_PART = 2'd2,  // faulting-part address when split
    TV_INSN = 2'd3   // instruction bits
  } tv_class_e;

endpackage

// File: rtl/tv_rst_sync.sv
module tv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/tv_class_decode.sv
module tv_class_decode
  import sv_trapval_pkg::*;
#(
  parameter int unsigned CAUSE_W   = 5,
  parameter logic [(2**CAUSE_W)-1:0] ZERO_MASK = '0
) (
  input  logic [CAUSE_W-1:0] cause_i,
  output tv_class_e          class_o
);

  tv_class_e base_class;

  always_comb begin
    case (int'(cause_i))
      CAUSE_FETCH_MISAL,
      CAUSE_BREAK,
      CAUSE_LOAD_MISAL,
      CAUSE_STORE_MISAL: base_class = TV_ADDR;
      CAUSE_FETCH_ACC,
      CAUSE_LOAD_ACC,
      CAUSE_STORE_ACC,
      CAUSE_FETCH_PAGE,
      CAUSE_LOAD_PAGE,
      CAUSE_STORE_PAGE:  base_class = TV_PART;
      CAUSE_ILLEGAL:     base_class = TV_INSN;
      default:           base_class = TV_ZERO;
    endcase
  end

  // Platform mask overrides the class
  always_comb begin
    if (ZERO_MASK[cause_i]) class_o = TV_ZERO;
    else                    class_o = base_class;
  end

endmodule

// File: rtl/tv_value_select.sv
module tv_value_select
  import sv_trapval_pkg::*;
#(
  parameter int unsigned XLEN         = 64,
  parameter int unsigned ILEN         = 32,
  parameter bit          INSN_CAPTURE = 1'b1
) (
  input  tv_class_e        class_i,
  input  logic             split_i,
  input  logic [XLEN-1:0]  fault_va_i,
  input  logic [XLEN-1:0]  part_va_i,
  input  logic [ILEN-1:0]  insn_i,
  output logic [XLEN-1:0]  value_o
);

  localparam int unsigned PAD_W = XLEN - ILEN;

  logic [XLEN-1:0] insn_val;

  generate
    if (INSN_CAPTURE) begin : g_insn_on
      assign insn_val = {{PAD_W{1'b0}}, insn_i};
    end else begin : g_insn_off
      assign insn_val = '0;
    end
  endgenerate

  always_comb begin
    case (class_i)
      TV_ADDR: value_o = fault_va_i;
      TV_PART: value_o = split_i ? part_va_i : fault_va_i;
      TV_INSN: value_o = insn_val;
      default: value_o = '0;
    endcase
  end

endmodule

// File: rtl/tv_store.sv
module tv_store #(
  parameter int unsigned XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_i,
  input  logic [XLEN-1:0]  trap_val_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic             sw_we_i,
  input  logic [XLEN-1:0]  sw_wdata_i,
  output logic [XLEN-1:0]  tval_o,
  output logic [XLEN-1:0]  epc_o
);

  logic [XLEN-1:0] tval_q, tval_d;
  logic [XLEN-1:0] epc_q,  epc_d;
  logic            tval_en;
  logic            epc_en;

  always_comb begin
    tval_en = trap_i | sw_we_i;
    tval_d  = trap_i ? trap_val_i : sw_wdata_i;  // trap has priority
    epc_en  = trap_i;
    epc_d   = pc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tval_q <= '0;
      epc_q  <= '0;
    end else begin
      if (tval_en) tval_q <= tval_d;
      if (epc_en)  epc_q  <= epc_d;
    end
  end

  assign tval_o = tval_q;
  assign epc_o  = epc_q;

endmodule

// File: rtl/sv_trapval.sv
module sv_trapval
  import sv_trapval_pkg::*;
#(
  parameter int unsigned XLEN         = 64,
  parameter int unsigned ILEN         = 32,
  parameter int unsigned CAUSE_W      = 5,
  parameter bit          INSN_CAPTURE = 1'b1,
  parameter logic [(2**CAUSE_W)-1:0] ZERO_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    fault_va_i,
  input  logic               split_i,
  input  logic [XLEN-1:0]    part_va_i,
  input  logic [ILEN-1:0]    insn_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               sw_we_i,
  input  logic [XLEN-1:0]    sw_wdata_i,
  output logic [XLEN-1:0]    tval_o,
  output logic [XLEN-1:0]    epc_o
);

  logic            rst_sync_n;
  tv_class_e       cap_class;
  logic [XLEN-1:0] cap_value;

  tv_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tv_class_decode #(
    .CAUSE_W   (CAUSE_W),
    .ZERO_MASK (ZERO_MASK)
  ) u_decode (
    .cause_i (cause_i),
    .class_o (cap_class)
  );

  tv_value_select #(
    .XLEN         (XLEN),
    .ILEN         (ILEN),
    .INSN_CAPTURE (INSN_CAPTURE)
  ) u_select (
    .class_i    (cap_class),
    .split_i    (split_i),
    .fault_va_i (fault_va_i),
    .part_va_i  (part_va_i),
    .insn_i     (insn_i),
    .value_o    (cap_value)
  );

  tv_store #(
    .XLEN (XLEN)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trap_i     (trap_i),
    .trap_val_i (cap_value),
    .pc_i       (pc_i),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .tval_o     (tval_o),
    .epc_o      (epc_o)
  );

endmodule

// File: rtl/sv_trapval_chk.sv
module sv_trapval_chk
  import sv_trapval_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_W = 5,
  parameter logic [(2**CAUSE_W)-1:0] ZERO_MASK = '0
) (
  input logic               clk,
  input logic               rst_ok_n,
  input logic               trap_i,
  input logic [CAUSE_W-1:0] cause_i,
  input logic [XLEN-1:0]    fault_va_i,
  input logic               split_i,
  input logic [XLEN-1:0]    part_va_i,
  input logic [XLEN-1:0]    pc_i,
  input logic               sw_we_i,
  input logic [XLEN-1:0]    sw_wdata_i,
  input logic [XLEN-1:0]    tval_o,
  input logic [XLEN-1:0]    epc_o
);

  logic is_part_cause;
  logic is_addr_cause;
  logic masked;

  always_comb begin
    is_part_cause = (int'(cause_i) == CAUSE_FETCH_ACC)  || (int'(cause_i) == CAUSE_LOAD_ACC) ||
                    (int'(cause_i) == CAUSE_STORE_ACC)  || (int'(cause_i) == CAUSE_FETCH_PAGE) ||
                    (int'(cause_i) == CAUSE_LOAD_PAGE)  || (int'(cause_i) == CAUSE_STORE_PAGE);
    is_addr_cause = (int'(cause_i) == CAUSE_FETCH_MISAL) || (int'(cause_i) == CAUSE_BREAK) ||
                    (int'(cause_i) == CAUSE_LOAD_MISAL)  || (int'(cause_i) == CAUSE_STORE_MISAL);
    masked        = ZERO_MASK[cause_i];
  end

  AST_TVAL_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!trap_i && !sw_we_i) |=> $stable(tval_o)); // R2

  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!trap_i && sw_we_i) |=> (tval_o == $past(sw_wdata_i))); // R3

  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (trap_i && is_addr_cause && !masked) |=> (tval_o == $past(fault_va_i))); // R5

  AST_PART_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (trap_i && is_part_cause && split_i && !masked) |=> (tval_o == $past(part_va_i))); // R6

  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (trap_i && masked) |=> (tval_o == '0)); // R9

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    trap_i |=> (epc_o == $past(pc_i))); // R10

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !trap_i |=> $stable(epc_o)); // R10

endmodule

bind sv_trapval sv_trapval_chk #(
  .XLEN      (XLEN),
  .CAUSE_W   (CAUSE_W),
  .ZERO_MASK (ZERO_MASK)
) u_chk (
  .clk        (clk),
  .rst_ok_n   (rst_sync_n),
  .trap_i     (trap_i),
  .cause_i    (cause_i),
  .fault_va_i (fault_va_i),
  .split_i    (split_i),
  .part_va_i  (part_va_i),
  .pc_i       (pc_i),
  .sw_we_i    (sw_we_i),
  .sw_wdata_i (sw_wdata_i),
  .tval_o     (tval_o),
  .epc_o      (epc_o)
);

// File: tb/sv_trapval_bench.sv
`timescale 1ns/1ps
module sv_trapval_bench;

  localparam int unsigned XLEN = 64;
  localparam int unsigned ILEN = 32;
  localparam int unsigned CW   = 5;
  // causes 3 (breakpoint) and 13 (load page fault) forced to zero
  localparam logic [31:0] MASK = 32'h0000_2008;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            trap;
  logic [CW-1:0]   cause;
  logic [XLEN-1:0] fva;
  logic            split;
  logic [XLEN-1:0] pva;
  logic [ILEN-1:0] insn;
  logic [XLEN-1:0] pc;
  logic            swe;
  logic [XLEN-1:0] swd;
  logic [XLEN-1:0] tval, epc, tval_b, epc_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [XLEN-1:0] exp_tval, exp_epc, exp_tval_b;

  always #2 clk = ~clk;  // 250 MHz

  sv_trapval #(.XLEN(XLEN), .ILEN(ILEN), .CAUSE_W(CW), .INSN_CAPTURE(1'b1), .ZERO_MASK(MASK))
  u_sv_trapval (
    .clk(clk), .rst_n(rst_n), .trap_i(trap), .cause_i(cause), .fault_va_i(fva),
    .split_i(split), .part_va_i(pva), .insn_i(insn), .pc_i(pc), .sw_we_i(swe),
    .sw_wdata_i(swd), .tval_o(tval), .epc_o(epc)
  );

  sv_trapval #(.XLEN(XLEN), .ILEN(ILEN), .CAUSE_W(CW), .INSN_CAPTURE(1'b0), .ZERO_MASK(MASK))
  u_sv_trapval_noinsn (
    .clk(clk), .rst_n(rst_n), .trap_i(trap), .cause_i(cause), .fault_va_i(fva),
    .split_i(split), .part_va_i(pva), .insn_i(insn), .pc_i(pc), .sw_we_i(swe),
    .sw_wdata_i(swd), .tval_o(tval_b), .epc_o(epc_b)
  );

  function automatic logic [XLEN-1:0] r64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [XLEN-1:0] model_val(input logic [CW-1:0] c, input logic sp,
      input logic [XLEN-1:0] va, input logic [XLEN-1:0] pa, input logic [ILEN-1:0] ins,
      input bit ins_en);
    if (MASK[c]) return '0;
    case (int'(c))
      0, 3, 4, 6:             return va;
      1, 5, 7, 12, 13, 15:    return sp ? pa : va;
      2:                      return ins_en ? {{(XLEN-ILEN){1'b0}}, ins} : '0;
      default:                return '0;
    endcase
  endfunction

  function automatic string req_of(input logic t, input logic [CW-1:0] c, input logic w);
    if (!t) return w ? "R3" : "R2";
    if (MASK[c]) return "R9";
    case (int'(c))
      0, 3, 4, 6:          return w ? "R4" : "R5";
      1, 5, 7, 12, 13, 15: return w ? "R4" : "R6";
      2:                   return "R7";
      default:             return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp,
                       input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // One cycle: drive at negedge, compute expected, compare after the edge
  task automatic step(input logic t, input logic [CW-1:0] c, input logic sp,
                      input logic [XLEN-1:0] va, input logic [XLEN-1:0] pa,
                      input logic [ILEN-1:0] ins, input logic [XLEN-1:0] p,
                      input logic w, input logic [XLEN-1:0] wd);
    string req;
    @(negedge clk);
    trap = t; cause = c; split = sp; fva = va; pva = pa; insn = ins; pc = p; swe = w; swd = wd;
    req = req_of(t, c, w);
    if (t) begin
      exp_tval   = model_val(c, sp, va, pa, ins, 1'b1);
      exp_tval_b = model_val(c, sp, va, pa, ins, 1'b0);
      exp_epc    = p;
    end else if (w) begin
      exp_tval   = wd;
      exp_tval_b = wd;
    end
    @(posedge clk);
    #1;
    check(req, tval, exp_tval, "tval");
    check("R10", epc, exp_epc, "epc");
    if (t && int'(c) == 2) check("R7", tval_b, exp_tval_b, "tval without insn capture");
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, r64(), r64(), $urandom, r64(), 1'b0, r64());
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin : stim
    int causes[16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 11, 12, 13, 15, 14, 24};
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    trap = 1'b0; cause = '0; split = 1'b0; fva = '0; pva = '0; insn = '0; pc = '0;
    swe = 1'b0; swd = '0;
    exp_tval = '0; exp_epc = '0; exp_tval_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", tval, '0, "tval in reset");
    check("R1", epc, '0, "epc in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
    check("R1", tval, '0, "tval after reset");
    check("R1", epc, '0, "epc after reset");

    // directed corners
    step(1'b0, '0, 1'b0, '0, '0, '0, '0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);           // R3
    idle(); idle();                                                                // R2
    step(1'b1, 5'd1, 1'b1, 64'h1000_0FFE, 64'h1000_1000, '0, 64'h1000_0FFE, 1'b0, '0); // R6 split fetch
    step(1'b1, 5'd5, 1'b0, 64'h2000_0003, 64'h2000_1000, '0, 64'h400, 1'b0, '0);   // R6 unsplit
    step(1'b1, 5'd4, 1'b1, 64'h3000_0007, 64'h3000_1000, '0, 64'h404, 1'b0, '0);   // R5 ignores split
    step(1'b1, 5'd7, 1'b1, 64'h4FFC, 64'h5000, '0, 64'h408, 1'b1, 64'hDEAD_BEEF); // R4 trap beats write
    step(1'b1, 5'd2, 1'b0, r64(), r64(), 32'hFFFF_FFFF, 64'h40C, 1'b0, '0);       // R7
    step(1'b1, 5'd3, 1'b0, 64'h8888, r64(), '0, 64'h410, 1'b0, '0);               // R9 breakpoint masked
    step(1'b1, 5'd13, 1'b1, r64(), r64(), '0, 64'h414, 1'b0, '0);                 // R9 load page masked
    step(1'b1, 5'd9, 1'b0, r64(), r64(), $urandom, 64'h418, 1'b0, '0);            // R8
    step(1'b0, '0, 1'b0, '0, '0, '0, '0, 1'b1, 64'h1234_5678_9ABC_DEF0);          // R3, R10 hold
    idle();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic t;
      logic w;
      t = ($urandom_range(0, 2) == 0);
      w = ($urandom_range(0, 3) == 0);
      step(t, CW'(causes[$urandom_range(0, 15)]), $urandom_range(0, 1) == 1,
           r64(), r64(), $urandom, r64(), w, r64());
    end
    finish_run();
  end

endmodule